// File: doc/BRIEF.md
# Deep Sleep Wake Controller

This block controls a small controller's deepest sleep state. It runs from an always-on clock and sits beside the core's power switch. Software starts sleep through a register port by writing two key values on consecutive cycles. The block then freezes the I/O pads. One cycle later it removes core power and holds the core in reset. While the core is unpowered, the block watches a fixed set of wake events: the external reset pin, a real-time-clock alarm, an external interrupt and the sleep watchdog. The last three can each be masked.

A wake event does not resume the core. The block restores power, keeps the core in reset for a programmable number of cycles and then releases it, so the core restarts from its reset vector. Software can identify this kind of restart from three things:
- a sticky status bit;
- a one-hot flag for each wake cause;
- two retention registers, which keep their contents through sleep while the wake mask returns to its default.

The pads stay frozen until software writes a zero to bit 0 of the control register.

Top module: `dsw_ctrl_top`

## Requirements
- R1: After the synchronous reset (the power-on event), core power is on and core reset is released. Pads are not held. The cause flags read 5'b00001 (bit 0 = power-on), the control register reads 0, the mask reads 3'b111, and both retention registers read 0.
- R2: Sleep entry needs a write of KEY_FIRST and then a write of KEY_SECOND to address 4 on consecutive cycles. Pad hold rises at the clock edge that samples the second write. Any other order, or a gap between the two writes, has no effect.
- R3: Core power drops exactly one cycle after pad hold rises, and core reset asserts in the same cycle. Whenever power is off, reset and pad hold are both asserted.
- R4: Wake events are honoured only while asleep. The reset pin always wakes the block. Alarm, interrupt and watchdog wake it only when mask bits 0, 1 and 2 (address 5) are set. An event while running or a masked event sets no flag and leaves power unchanged.
- R5: Power returns at the clock edge that samples a wake event. Core reset stays asserted for PWRUP_CYC cycles after that edge and is released at the edge PWRUP_CYC cycles later.
- R6: On wake, the cause register (address 1) ORs in one bit for every enabled active source: bit 1 pin, bit 2 alarm, bit 3 interrupt, bit 4 watchdog. Writing ones clears the matching bits.
- R7: Control register bit 1 (address 0) is set by a wake and cleared by writing 1 to it. Bit 0 reads the pad-hold state.
- R8: Pad hold persists through sleep and the wake reset. It clears only on a write to address 0 with bit 0 at zero.
- R9: The retention registers (addresses 2 and 3) keep their values across sleep. The wake mask returns to 3'b111 on every wake.
- R10: Register writes issued while the block is not running have no effect.
- R11: Read data is registered: the value for an address appears one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wk_pin_rst | input | 1 | External reset pin event (synchronized) |
| wk_rtc_alarm | input | 1 | Real-time-clock alarm |
| wk_ext_irq | input | 1 | External interrupt |
| wk_wdt_expire | input | 1 | Sleep watchdog expiry |
| core_pwr_en | output | 1 | Core power enable |
| core_rst | output | 1 | Core reset, active high |
| pad_hold | output | 1 | Freeze I/O pad state |

## Verification
Pad hold is due one clock after the second key write, and power loss one clock after that. Power returns at the edge that samples a wake event, and core reset falls PWRUP_CYC edges later. Inputs are driven on falling edges and outputs are sampled on later falling edges, so the bench checks reset as still high at the PWRUP_CYC-th falling edge after wake and as low at the next one. Read data is checked one cycle after the address. A separate check confirms that the old value is still present in the cycle the address changes.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_SLEEP, ST_PWRUP} dsw_state_e;

  localparam int SRC_N   = 5;
  localparam int SRC_POR = 0;
  localparam int SRC_PIN = 1;
  localparam int SRC_RTC = 2;
  localparam int SRC_IRQ = 3;
  localparam int SRC_WDT = 4;
  localparam int MASK_N  = 3;

  localparam int A_CTRL  = 0;
  localparam int A_FLAGS = 1;
  localparam int A_RET0  = 2;
  localparam int A_RET1  = 3;
  localparam int A_KEY   = 4;
  localparam int A_MASK  = 5;
endpackage

// File: rtl/dsw_unlock.sv
module dsw_unlock #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'('h5A5A),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'('hC3C3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              key_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              enter
);
  logic armed_q;
  logic key_wr;

  assign key_wr = wr_ok && key_hit;
  assign enter  = key_wr && armed_q && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= key_wr && (wdata == KEY_FIRST);
  end
endmodule

// File: rtl/dsw_wake_gate.sv
module dsw_wake_gate
  import dsw_pkg::*;
(
  input  logic              pin,
  input  logic              rtc,
  input  logic              irq,
  input  logic              wdt,
  input  logic [MASK_N-1:0] mask,
  output logic [SRC_N-1:0]  cause,
  output logic              any
);
  always_comb begin
    cause          = '0;
    cause[SRC_PIN] = pin;
    cause[SRC_RTC] = rtc && mask[0];
    cause[SRC_IRQ] = irq && mask[1];
    cause[SRC_WDT] = wdt && mask[2];
    any            = |cause;
  end
endmodule

// File: rtl/dsw_seq.sv
module dsw_seq
  import dsw_pkg::*;
#(
  parameter int PWRUP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic wake_any,
  input  logic release_req,
  output logic in_run,
  output logic wake_take,
  output logic pwr_en,
  output logic core_rst,
  output logic pad_hold
);
  localparam int CNT_W = $clog2(PWRUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYC - 1);

  dsw_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_run    = (state_q == ST_RUN);
  assign wake_take = (state_q == ST_SLEEP) && wake_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      cnt_q    <= '0;
      pwr_en   <= 1'b1;
      core_rst <= 1'b1;
      pad_hold <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          core_rst <= 1'b0;
          if (enter) begin
            state_q  <= ST_ENTER;
            pad_hold <= 1'b1;
          end else if (release_req) begin
            pad_hold <= 1'b0;
          end
        end
        ST_ENTER: begin
          state_q  <= ST_SLEEP;
          pwr_en   <= 1'b0;
          core_rst <= 1'b1;
        end
        ST_SLEEP: begin
          if (wake_any) begin
            state_q <= ST_PWRUP;
            pwr_en  <= 1'b1;
            cnt_q   <= '0;
          end
        end
        ST_PWRUP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_q  <= ST_RUN;
            core_rst <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/dsw_regs.sv
module dsw_regs
  import dsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake_take,
  input  logic [SRC_N-1:0]  cause,
  input  logic              pad_hold,
  output logic              release_req,
  output logic              key_hit,
  output logic [MASK_N-1:0] mask,
  output logic [DATA_W-1:0] rdata
);
  logic [SRC_N-1:0]  flags_q;
  logic              woke_q;
  logic [DATA_W-1:0] ret_q [2];
  logic [DATA_W-1:0] rd_mux;

  assign key_hit     = (addr == ADDR_W'(A_KEY));
  assign release_req = wr_ok && (addr == ADDR_W'(A_CTRL)) && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= SRC_N'(1) << SRC_POR;
      woke_q  <= 1'b0;
      mask    <= '1;
    end else if (wake_take) begin
      flags_q <= flags_q | cause;
      woke_q  <= 1'b1;
      mask    <= '1;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(A_FLAGS)) flags_q <= flags_q & ~wdata[SRC_N-1:0];
      if (addr == ADDR_W'(A_CTRL) && wdata[1]) woke_q <= 1'b0;
      if (addr == ADDR_W'(A_MASK)) mask <= wdata[MASK_N-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ret
    always_ff @(posedge clk) begin
      if (rst) ret_q[g] <= '0;
      else if (wr_ok && addr == ADDR_W'(A_RET0 + g)) ret_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_CTRL):  rd_mux = DATA_W'({woke_q, pad_hold});
      ADDR_W'(A_FLAGS): rd_mux = DATA_W'(flags_q);
      ADDR_W'(A_RET0):  rd_mux = ret_q[0];
      ADDR_W'(A_RET1):  rd_mux = ret_q[1];
      ADDR_W'(A_MASK):  rd_mux = DATA_W'(mask);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/dsw_ctrl_top.sv
module dsw_ctrl_top
  import dsw_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int PWRUP_CYC = 4,
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'('h5A5A),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'('hC3C3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wk_pin_rst,
  input  logic              wk_rtc_alarm,
  input  logic              wk_ext_irq,
  input  logic              wk_wdt_expire,
  output logic              core_pwr_en,
  output logic              core_rst,
  output logic              pad_hold
);
  logic              in_run, wr_ok, enter, key_hit;
  logic              wake_any, wake_take, release_req;
  logic [SRC_N-1:0]  cause;
  logic [MASK_N-1:0] mask;

  assign wr_ok = bus_we && in_run;

  dsw_unlock #(.DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .key_hit(key_hit),
    .wdata(bus_wdata), .enter(enter)
  );

  dsw_wake_gate u_gate (
    .pin(wk_pin_rst), .rtc(wk_rtc_alarm), .irq(wk_ext_irq), .wdt(wk_wdt_expire),
    .mask(mask), .cause(cause), .any(wake_any)
  );

  dsw_seq #(.PWRUP_CYC(PWRUP_CYC)) u_seq (
    .clk(clk), .rst(rst), .enter(enter), .wake_any(wake_any),
    .release_req(release_req), .in_run(in_run), .wake_take(wake_take),
    .pwr_en(core_pwr_en), .core_rst(core_rst), .pad_hold(pad_hold)
  );

  dsw_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .wake_take(wake_take), .cause(cause), .pad_hold(pad_hold),
    .release_req(release_req), .key_hit(key_hit), .mask(mask), .rdata(bus_rdata)
  );
endmodule

// File: rtl/dsw_ctrl_chk.sv
module dsw_ctrl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_bit0,
  input logic              core_pwr_en,
  input logic              core_rst,
  input logic              pad_hold
);
  assert_pwr_after_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_hold) |=> $fell(core_pwr_en));

  assert_off_state_R3: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_en |-> (core_rst && pad_hold));

  assert_pwr_before_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (core_pwr_en && $past(core_pwr_en)));

  assert_pwr_up_in_reset_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_pwr_en) |-> core_rst);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_hold) |-> $past(bus_we && bus_addr == '0 && !wr_bit0));
endmodule

bind dsw_ctrl_top dsw_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_bit0(bus_wdata[0]), .core_pwr_en(core_pwr_en),
  .core_rst(core_rst), .pad_hold(pad_hold)
);

// File: tb/dsw_ctrl_tb.sv
module dsw_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int PWRUP = 4;
  localparam logic [DW-1:0] K1 = 16'h5A5A;
  localparam logic [DW-1:0] K2 = 16'hC3C3;
  // {mask[2:0], src{wdt,irq,rtc,pin}, expected flags[4:0]}
  localparam logic [11:0] VEC [8] = '{
    {3'b111, 4'b0001, 5'b00010},
    {3'b111, 4'b0010, 5'b00100},
    {3'b111, 4'b0100, 5'b01000},
    {3'b111, 4'b1000, 5'b10000},
    {3'b001, 4'b1110, 5'b00100},
    {3'b000, 4'b1111, 5'b00010},
    {3'b110, 4'b1010, 5'b10000},
    {3'b111, 4'b1111, 5'b11110}
  };

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [3:0] src = '0;
  logic core_pwr_en, core_rst, pad_hold;
  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsw_ctrl_top #(.DATA_W(DW), .ADDR_W(AW), .PWRUP_CYC(PWRUP), .KEY_FIRST(K1), .KEY_SECOND(K2)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wk_pin_rst(src[0]), .wk_rtc_alarm(src[1]),
    .wk_ext_irq(src[2]), .wk_wdt_expire(src[3]), .core_pwr_en(core_pwr_en),
    .core_rst(core_rst), .pad_hold(pad_hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic unlock();
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(4); bus_wdata = K1;
    @(negedge clk); bus_wdata = K2;
    @(negedge clk); bus_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr", int'(core_pwr_en), 1);
    chk("R1 rst", int'(core_rst), 0);
    chk("R1 hold", int'(pad_hold), 0);
    rd(1, rv); chk("R1 flags", int'(rv), 1);
    rd(0, rv); chk("R1 ctrl", int'(rv), 0);
    rd(5, rv); chk("R1 mask", int'(rv), 7);
    rd(2, rv); chk("R1 ret0", int'(rv), 0);
    wr(3, 16'h1234);

    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      v = VEC[i];
      wr(1, 16'h1F); wr(0, 16'h2); wr(5, DW'(v[11:9])); wr(2, DW'(16'hA500 + i));
      unlock();
      chk("R2 hold on entry", int'(pad_hold), 1);
      chk("R3 pwr kept", int'(core_pwr_en), 1);
      @(negedge clk);
      chk("R3 pwr off", int'(core_pwr_en), 0);
      chk("R3 rst on", int'(core_rst), 1);
      wr(3, 16'hFFFF);                       // R10 write while asleep
      @(negedge clk); src = v[8:5];
      @(negedge clk); src = '0;
      chk("R5 pwr back", int'(core_pwr_en), 1);
      chk("R5 rst held", int'(core_rst), 1);
      repeat (PWRUP - 1) @(negedge clk);
      chk("R5 rst still held", int'(core_rst), 1);
      @(negedge clk);
      chk("R5 rst released", int'(core_rst), 0);
      rd(1, rv); chk("R6 R4 cause flags", int'(rv), int'(v[4:0]));
      rd(0, rv); chk("R7 ctrl after wake", int'(rv), 3);
      rd(5, rv); chk("R9 mask default", int'(rv), 7);
      rd(2, rv); chk("R9 ret0 kept", int'(rv), 16'hA500 + i);
      rd(3, rv); chk("R10 ret1 unchanged", int'(rv), 16'h1234);
      chk("R8 hold after wake", int'(pad_hold), 1);
      wr(0, 16'h0);
      chk("R8 released", int'(pad_hold), 0);
      rd(0, rv); chk("R7 woke kept", int'(rv), 2);
    end

    // R6 partial clear
    rd(1, rv); chk("R6 flags", int'(rv), 16'h1E);
    wr(1, 16'h06);
    rd(1, rv); chk("R6 w1c", int'(rv), 16'h18);

    // R11 read latency
    rd(2, rv);
    @(negedge clk); bus_addr = AW'(5);
    chk("R11 old data", int'(bus_rdata), 16'hA507);
    @(negedge clk);
    chk("R11 new data", int'(bus_rdata), 7);

    // R2 broken sequences
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(4); bus_wdata = K1;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk); bus_we = 1'b1; bus_wdata = K2;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    chk("R2 gap rejected", int'(pad_hold), 0);
    @(negedge clk); bus_we = 1'b1; bus_wdata = K2;
    @(negedge clk); bus_wdata = K1;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    chk("R2 order rejected", int'(pad_hold), 0);
    chk("R2 pwr on", int'(core_pwr_en), 1);

    // R4 events while running
    wr(1, 16'h1F);
    @(negedge clk); src = 4'hF;
    @(negedge clk); src = '0;
    chk("R4 run pwr", int'(core_pwr_en), 1);
    rd(1, rv); chk("R4 no flags in run", int'(rv), 0);

    // R4 masked sources while asleep
    wr(5, 16'h0);
    unlock();
    @(negedge clk); src = 4'b1110;
    repeat (5) @(negedge clk);
    chk("R4 masked no wake", int'(core_pwr_en), 0);
    src = 4'b1111;
    @(negedge clk); src = '0;
    chk("R4 pin wakes", int'(core_pwr_en), 1);
    repeat (PWRUP) @(negedge clk);
    chk("R5 rst released", int'(core_rst), 0);
    rd(1, rv); chk("R4 pin only flag", int'(rv), 2);

    // R8 release needs bit0 = 0
    wr(0, 16'h1);
    chk("R8 bit0 one keeps hold", int'(pad_hold), 1);
    wr(0, 16'h3);
    rd(0, rv); chk("R7 woke cleared", int'(rv), 1);
    wr(0, 16'h0);
    chk("R8 released", int'(pad_hold), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule